// File: doc/BRIEF.md
# Nonvolatile Commit and Power-Up Recall Sequencer

This block drives the nonvolatile side of a digital potentiometer. Coming out of reset it holds the wiper at midscale and stays busy. When the nonvolatile array reports that it can be read, the block copies the stored start-up value into the wiper once. It then leaves the power-up phase.

After that it waits for the serial front end to flag a nonvolatile write whose final data byte has been acknowledged. The write is held armed until the next bus event. A stop condition that comes next launches a timed programming cycle. Anything else drops the write: any other bus activity, a further data byte, or the write-protect input going low. During the programming cycle the block raises busy so that the front end stays silent. When the cycle ends, the block issues a one-cycle commit strobe carrying the captured address and data.

The cycle length is a parameter in system-clock cycles. A long value suits silicon and a short one suits simulation.

Top module: `nv_commit_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `wiper_val` is 80h (`1 << (DW-1)`), `busy` is 1, and `commit_stb` and `wiper_ld` are 0.
- R2: The first clock edge that samples `mem_ready` high after reset has three effects at once: `wiper_val` takes `nv_init_val`, `wiper_ld` pulses for one cycle, and `busy` falls. Later changes on `mem_ready` or `nv_init_val` leave `wiper_val` unchanged.
- R3: A write is captured by `wr_pend` (while `wp_n` is high). If `stop_det` is sampled on the next clock edge, the programming cycle begins and `busy` is 1 from that edge.
- R4: If `bus_evt` is sampled in the cycle after the capture, the write is dropped. A later `stop_det` then starts no cycle and produces no commit.
- R5: `wp_n` low drops the write if it is low at the capture, or low in the armed cycle (even together with `stop_det`).
- R6: `wp_n` going low after the programming cycle has begun has no effect. The commit still occurs with the captured address and data.
- R7: `busy` stays high for exactly `PROG_CYCLES` cycles of a programming cycle. `commit_stb` is high for one cycle, in the first cycle with `busy` low again, and carries the captured `commit_addr` and `commit_data`.
- R8: A second `wr_pend` sampled while a write is armed drops the armed write, so writing does not continue past a nonvolatile data byte.
- R9: `wr_pend` and `stop_det` are ignored while a programming cycle runs. They cause no extra commit and do not change the committed data.
- R10: Before the recall of R2, `wr_pend` and `stop_det` are ignored. No commit follows from them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| mem_ready | input | 1 | Nonvolatile array can be read |
| nv_init_val | input | DW | Stored start-up wiper value |
| wr_pend | input | 1 | Final data byte of a nonvolatile write was acknowledged (one-cycle pulse) |
| wr_addr | input | AW | Register address of the pending write |
| wr_data | input | DW | Data of the pending write |
| stop_det | input | 1 | Stop condition seen on the bus (one-cycle pulse) |
| bus_evt | input | 1 | Any other bus activity (start, clock edge) |
| wp_n | input | 1 | Write protect, active low |
| busy | output | 1 | Power-up recall or programming cycle in progress |
| commit_stb | output | 1 | One-cycle strobe: store `commit_data` at `commit_addr` |
| commit_addr | output | AW | Address of the committed write |
| commit_data | output | DW | Data of the committed write |
| wiper_ld | output | 1 | One-cycle strobe: wiper loaded from the stored value |
| wiper_val | output | DW | Current wiper position |

## Verification
The assertions rely on the front end presenting `wr_pend`, `stop_det` and `bus_evt` as single-cycle pulses. They also rely on `mem_ready`, once raised, marking a genuine readable state, so that recall happens exactly once per reset. The stimulus drives every input on the falling clock edge and holds each pulse for exactly one cycle. The bench deliberately overlaps `wp_n`, `wr_pend` and `stop_det` in the armed and programming states, so that the priority of cancellation over start is exercised.

// File: rtl/nv_commit_seq.sv
module nv_commit_seq #(
  parameter int DW          = 8,
  parameter int AW          = 4,
  parameter int PROG_CYCLES = 200000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mem_ready,
  input  logic [DW-1:0] nv_init_val,
  input  logic          wr_pend,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          stop_det,
  input  logic          bus_evt,
  input  logic          wp_n,
  output logic          busy,
  output logic          commit_stb,
  output logic [AW-1:0] commit_addr,
  output logic [DW-1:0] commit_data,
  output logic          wiper_ld,
  output logic [DW-1:0] wiper_val
);
  localparam int CW = (PROG_CYCLES > 2) ? $clog2(PROG_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(PROG_CYCLES - 1);
  localparam logic [DW-1:0] MID  = DW'(1) << (DW - 1);

  typedef enum logic [1:0] {S_PWR, S_IDLE, S_ARM, S_PROG} st_t;
  st_t st;
  logic [CW-1:0] cnt;

  assign busy = (st == S_PWR) || (st == S_PROG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_PWR;
      cnt         <= '0;
      wiper_val   <= MID;
      wiper_ld    <= 1'b0;
      commit_stb  <= 1'b0;
      commit_addr <= '0;
      commit_data <= '0;
    end else begin
      wiper_ld   <= 1'b0;
      commit_stb <= 1'b0;
      case (st)
        S_PWR: if (mem_ready) begin
          wiper_val <= nv_init_val;
          wiper_ld  <= 1'b1;
          st        <= S_IDLE;
        end
        S_IDLE: if (wr_pend && wp_n) begin
          commit_addr <= wr_addr;
          commit_data <= wr_data;
          st          <= S_ARM;
        end
        S_ARM: begin
          if (!wp_n || bus_evt || wr_pend) st <= S_IDLE;
          else if (stop_det) begin
            st  <= S_PROG;
            cnt <= '0;
          end
        end
        S_PROG: begin
          if (cnt == LAST) begin
            st         <= S_IDLE;
            commit_stb <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nv_commit_seq_chk.sv
module nv_commit_seq_chk #(
  parameter int DW          = 8,
  parameter int PROG_CYCLES = 200000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          commit_stb,
  input logic          wiper_ld,
  input logic [DW-1:0] wiper_val
);
  logic        seen_ld;
  logic [31:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_ld <= 1'b0;
      run     <= '0;
    end else begin
      if (wiper_ld) seen_ld <= 1'b1;
      run <= busy ? run + 32'd1 : 32'd0;
    end
  end

  a_r2_recall_once: assert property (@(posedge clk) disable iff (!rst_n)
    wiper_ld |-> !seen_ld);
  a_r2_wiper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wiper_ld |-> $stable(wiper_val));
  a_r7_strobe_at_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb |-> (!busy && $past(busy)));
  a_r7_cycle_len: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb |-> (run == 32'(PROG_CYCLES)));
  a_r10_no_commit_before_recall: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb |-> seen_ld);
  a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit_stb, wiper_ld}));
endmodule

bind nv_commit_seq nv_commit_seq_chk #(.DW(DW), .PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .commit_stb(commit_stb),
  .wiper_ld(wiper_ld), .wiper_val(wiper_val)
);

// File: tb/tb_nv_commit_seq.sv
module tb_nv_commit_seq;
  localparam int PROG = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mem_ready = 1'b0;
  logic [7:0] nv_init_val = 8'h00;
  logic       wr_pend = 1'b0;
  logic [3:0] wr_addr = 4'h0;
  logic [7:0] wr_data = 8'h00;
  logic       stop_det = 1'b0;
  logic       bus_evt = 1'b0;
  logic       wp_n = 1'b1;
  logic       busy, commit_stb, wiper_ld;
  logic [3:0] commit_addr;
  logic [7:0] commit_data, wiper_val;

  int checks = 0, fails = 0;
  int commit_cnt = 0, busy_cnt = 0, ld_cnt = 0, strobe_bad = 0;
  logic [3:0] last_addr = '0;
  logic [7:0] last_data = '0;
  int base_c, base_b, base_l;

  nv_commit_seq #(.DW(8), .AW(4), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .mem_ready(mem_ready), .nv_init_val(nv_init_val),
    .wr_pend(wr_pend), .wr_addr(wr_addr), .wr_data(wr_data),
    .stop_det(stop_det), .bus_evt(bus_evt), .wp_n(wp_n),
    .busy(busy), .commit_stb(commit_stb), .commit_addr(commit_addr),
    .commit_data(commit_data), .wiper_ld(wiper_ld), .wiper_val(wiper_val)
  );

  always #10 clk = ~clk;

  always @(negedge clk) if (rst_n) begin
    if (busy) busy_cnt++;
    if (wiper_ld) ld_cnt++;
    if (commit_stb) begin
      commit_cnt++;
      last_addr = commit_addr;
      last_data = commit_data;
      if (busy) strobe_bad++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic snap();
    @(negedge clk); #1;
    base_c = commit_cnt; base_b = busy_cnt; base_l = ld_cnt;
  endtask

  task automatic write_seq(input logic [3:0] a, input logic [7:0] d);
    wr_pend = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_pend = 1'b0; stop_det = 1'b1;
    step();
    stop_det = 1'b0;
  endtask

  task automatic t_reset();
    chk(wiper_val == 8'h80, "R1 wiper midscale", wiper_val, 8'h80);
    chk(busy == 1'b1, "R1 busy at power-up", busy, 1);
    chk(commit_stb == 1'b0 && wiper_ld == 1'b0, "R1 strobes idle", {commit_stb, wiper_ld}, 0);
  endtask

  task automatic t_early_write();
    snap();
    write_seq(4'h3, 8'h77);
    step(PROG + 4);
    chk(commit_cnt - base_c == 0, "R10 no commit before recall", commit_cnt - base_c, 0);
    chk(busy == 1'b1 && wiper_val == 8'h80, "R10 still waiting for recall", busy, 1);
  endtask

  task automatic t_recall();
    nv_init_val = 8'h3C; mem_ready = 1'b1;
    step();
    chk(wiper_ld == 1'b1, "R2 load strobe", wiper_ld, 1);
    chk(wiper_val == 8'h3C, "R2 recalled value", wiper_val, 8'h3C);
    chk(busy == 1'b0, "R2 busy released", busy, 0);
    snap();
    nv_init_val = 8'hA5; mem_ready = 1'b0;
    step();
    mem_ready = 1'b1;
    step(4);
    chk(wiper_val == 8'h3C, "R2 recall only once", wiper_val, 8'h3C);
    chk(ld_cnt - base_l == 0, "R2 no second load", ld_cnt - base_l, 0);
  endtask

  task automatic t_commit();
    snap();
    write_seq(4'h5, 8'h6B);
    chk(busy == 1'b1, "R3 stop starts cycle", busy, 1);
    step(PROG + 4);
    chk(commit_cnt - base_c == 1, "R7 one commit", commit_cnt - base_c, 1);
    chk(busy_cnt - base_b == PROG, "R7 busy length", busy_cnt - base_b, PROG);
    chk(last_addr == 4'h5 && last_data == 8'h6B, "R7 commit payload", {last_addr, last_data}, 12'h56B);
    chk(strobe_bad == 0, "R7 strobe after busy", strobe_bad, 0);
  endtask

  task automatic t_abort_bus();
    snap();
    wr_pend = 1'b1; wr_addr = 4'h2; wr_data = 8'hEE;
    step();
    wr_pend = 1'b0; bus_evt = 1'b1;
    step();
    bus_evt = 1'b0; stop_det = 1'b1;
    step();
    stop_det = 1'b0;
    step(PROG + 2);
    chk(commit_cnt - base_c == 0 && busy_cnt - base_b == 0, "R4 bus activity cancels",
        commit_cnt - base_c, 0);
  endtask

  task automatic t_wp_capture();
    snap();
    wp_n = 1'b0;
    write_seq(4'h4, 8'h12);
    wp_n = 1'b1;
    step(PROG + 2);
    chk(commit_cnt - base_c == 0 && busy_cnt - base_b == 0, "R5 protected at capture",
        commit_cnt - base_c, 0);
  endtask

  task automatic t_wp_armed();
    snap();
    wr_pend = 1'b1; wr_addr = 4'h4; wr_data = 8'h34;
    step();
    wr_pend = 1'b0; wp_n = 1'b0; stop_det = 1'b1;
    step();
    stop_det = 1'b0; wp_n = 1'b1;
    step(PROG + 2);
    chk(commit_cnt - base_c == 0 && busy_cnt - base_b == 0, "R5 protect while armed",
        commit_cnt - base_c, 0);
  endtask

  task automatic t_wp_prog();
    snap();
    write_seq(4'h2, 8'h11);
    wp_n = 1'b0;
    step(PROG + 3);
    wp_n = 1'b1;
    chk(commit_cnt - base_c == 1, "R6 commit despite protect", commit_cnt - base_c, 1);
    chk(last_addr == 4'h2 && last_data == 8'h11, "R6 payload", {last_addr, last_data}, 12'h211);
  endtask

  task automatic t_autoinc();
    snap();
    wr_pend = 1'b1; wr_addr = 4'h3; wr_data = 8'hAA;
    step();
    wr_addr = 4'h4; wr_data = 8'hBB;
    step();
    wr_pend = 1'b0; stop_det = 1'b1;
    step();
    stop_det = 1'b0;
    step(PROG + 2);
    chk(commit_cnt - base_c == 0, "R8 no write past nonvolatile byte", commit_cnt - base_c, 0);
  endtask

  task automatic t_ignore_busy();
    snap();
    write_seq(4'h6, 8'h42);
    step(2);
    wr_pend = 1'b1; wr_addr = 4'h7; wr_data = 8'h99;
    step();
    wr_pend = 1'b0; stop_det = 1'b1;
    step();
    stop_det = 1'b0;
    step(2 * PROG + 4);
    chk(commit_cnt - base_c == 1, "R9 single commit", commit_cnt - base_c, 1);
    chk(last_addr == 4'h6 && last_data == 8'h42, "R9 data unchanged", {last_addr, last_data}, 12'h642);
    chk(busy_cnt - base_b == PROG, "R9 no second cycle", busy_cnt - base_b, PROG);
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_early_write();
    t_recall();
    t_commit();
    t_abort_bus();
    t_wp_capture();
    t_wp_armed();
    t_wp_prog();
    t_autoinc();
    t_ignore_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule